// File: doc/BRIEF.md
# Addressed Two-Word Serial Responder

This block is the transmit half of an addressed remote station. A receiver elsewhere accepts a command that carries this station's address and then raises a one-cycle arm pulse. That pulse opens a short window. A rising edge on the send input inside that window starts a reply on the serial line. The reply is two 11-bit words sent back to back. The first word carries an identification byte and the second carries a status byte.

A free-running divider splits the oscillator clock into bit periods. Every word boundary falls on a divider wrap, so the start of the reply follows the bit-clock phase and not the exact cycle of the send edge. The identification byte is sampled at the last moment before its word begins. The status byte is sampled at the end of the second word's start bit. The line driver is inverted, so the output idles low and a start bit appears as a high level.

Top module: `duo_word_tx`

## Requirements
- R1: After reset the serial output is low and stays low while no reply is under way. The bit divider restarts from phase 0 at the first clock edge after reset is released.
- R2: A reply begins only on a rising edge of `send_i` while the arm flag is set. An arm pulse sets the flag. A send edge with the flag clear starts nothing, and a level held high from before the arm pulse starts nothing.
- R3: The arm flag clears at the WIN_BITS-th bit boundary after the arm pulse (a boundary is an edge where the divider phase is DIV-1). A send edge on that same boundary edge is still accepted. A send edge one cycle later is ignored.
- R4: Let the divider phase at the send edge be p, with DIV=64. The start bit appears 63-p cycles after the edge when p<32, 64 cycles after it when p=63, and 127-p cycles after it otherwise. This is between one half and one and a half bit times.
- R5: The reply is 22 bit periods of DIV cycles each: a start bit, the identification byte least significant bit first, an even-parity bit and a stop bit, followed at once by the same layout carrying the status byte. The parity bit makes the number of ones in the eight data bits plus parity even.
- R6: The output is inverted: a start bit is driven high, a stop bit low, and each data or parity bit as the complement of its value.
- R7: The identification byte is taken from the value of `id_i` at the clock edge one cycle before the first start bit appears. Later changes do not affect the reply.
- R8: The status byte is taken from the value of `stat_i` at the edge that ends the second start bit. Changes after that edge do not affect the reply.
- R9: A send edge while a reply is in progress is ignored, even if the arm flag is set. Accepting a send edge clears the arm flag, so a later edge without a new arm pulse starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse from the receiver that opens the send window |
| send_i | input | 1 | Send request; its rising edge is used |
| id_i | input | W | Identification byte for the first word |
| stat_i | input | W | Status byte for the second word |
| line_o | output | 1 | Inverted serial output |

## Verification
Two events can land on the same cycle. The first is a send edge that arrives exactly on the boundary where the arm window closes. The bench counts clock edges from reset to find that boundary, drives the edge onto it, and expects a reply whose start delay matches phase 63. It then repeats the sequence one cycle later and expects a silent line. The second case is a send edge together with a fresh arm pulse while a reply is already on the line. The bench decodes the reply in progress, expects it to be undisturbed, and expects no second reply afterwards.

// File: rtl/duo_word_tx.sv
module duo_word_tx #(
  parameter int DIV      = 64,
  parameter int W        = 8,
  parameter int WIN_BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_i,
  input  logic         send_i,
  input  logic [W-1:0] id_i,
  input  logic [W-1:0] stat_i,
  output logic         line_o
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam int FW   = W + 3;
  localparam int LAST = 2 * FW - 1;
  localparam int BW   = $clog2(2 * FW);
  localparam int WW   = $clog2(WIN_BITS + 1);

  logic [CW-1:0] cnt;
  logic [WW-1:0] win;
  logic [BW-1:0] bi;
  logic [FW-1:0] sh;
  logic send_q, armed, pend, late, busy;

  wire tick = (cnt == CW'(DIV - 1));
  wire rise = send_i & ~send_q;
  wire take = rise & armed & ~busy & ~pend;
  wire go   = tick & pend & ~late;

  assign line_o = busy & ~sh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      send_q <= 1'b0;
    end else begin
      cnt    <= tick ? '0 : cnt + 1'b1;
      send_q <= send_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      win   <= '0;
    end else if (take) begin
      armed <= 1'b0;
    end else if (arm_i) begin
      armed <= 1'b1;
      win   <= '0;
    end else if (armed && tick) begin
      if (win == WW'(WIN_BITS - 1)) armed <= 1'b0;
      else                          win   <= win + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0;
      late <= 1'b0;
    end else if (take) begin
      pend <= 1'b1;
      late <= (cnt >= CW'(HALF)) && !tick;
    end else if (tick && pend) begin
      if (late) late <= 1'b0;
      else      pend <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      bi   <= '0;
      sh   <= '0;
    end else if (go) begin
      busy <= 1'b1;
      bi   <= '0;
      sh   <= {1'b1, ^id_i, id_i, 1'b0};
    end else if (busy && tick) begin
      bi <= bi + 1'b1;
      if (bi == BW'(LAST))          busy <= 1'b0;
      else if (bi == BW'(FW - 1))   sh   <= {{(FW-1){1'b1}}, 1'b0};
      else if (bi == BW'(FW))       sh   <= {1'b1, 1'b1, ^stat_i, stat_i};
      else                          sh   <= sh >> 1;
    end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_o);                                                 // R1
  AST_ARM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> win < WW'(WIN_BITS));                                     // R3
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick) && line_o);                             // R4
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(line_o));                               // R5
  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bi != BW'(LAST)) |=> busy);                                // R9
  AST_ARM_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> !armed);                                            // R9
endmodule

// File: tb/tb_duo_word_tx.sv
module tb_duo_word_tx;
  localparam int DIV = 64;
  localparam int WIN = 8;
  localparam logic [23:0] VEC [5] = '{
    {8'hA5, 8'h3C, 8'd0},
    {8'h00, 8'hFF, 8'd31},
    {8'h81, 8'h7E, 8'd32},
    {8'hFF, 8'h00, 8'd63},
    {8'h5A, 8'h01, 8'd47}
  };

  logic clk = 0, rst_n = 0, arm_i = 0, send_i = 0;
  logic [7:0] id_i = 8'h00, stat_i = 8'h00;
  wire line_o;
  int cyc;
  int total = 0, bad = 0;

  duo_word_tx #(.DIV(DIV), .W(8), .WIN_BITS(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .send_i(send_i),
    .id_i(id_i), .stat_i(stat_i), .line_o(line_o));

  always #2 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] frame_exp(input logic [7:0] a, input logic [7:0] b);
    logic [21:0] v;
    v[0] = 1'b1;
    for (int i = 0; i < 8; i++) v[1+i] = ~a[i];
    v[9] = ~(^a); v[10] = 1'b0; v[11] = 1'b1;
    for (int i = 0; i < 8; i++) v[12+i] = ~b[i];
    v[20] = ~(^b); v[21] = 1'b0;
    return v;
  endfunction

  function automatic int delay_of(input int p);
    if (p == DIV - 1) return DIV;
    if (p < DIV / 2)  return DIV - 1 - p;
    return 2 * DIV - 1 - p;
  endfunction

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic go_phase(input int p);
    @(negedge clk);
    while (cyc % DIV != p) @(negedge clk);
  endtask

  task automatic pulse_arm;
    arm_i = 1; @(negedge clk); arm_i = 0;
  endtask

  task automatic send_edge(output int e);
    send_i = 1; e = cyc; @(negedge clk); send_i = 0;
  endtask

  task automatic wait_start(output int s);
    s = -1;
    for (int i = 0; i < 300; i++) begin
      if (line_o) begin s = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic recv(input int s, output logic [21:0] v);
    for (int k = 0; k < 22; k++) begin
      wait_cyc(s + DIV * k + DIV / 2);
      v[k] = line_o;
    end
  endtask

  task automatic quiet(input int n, output bit ok);
    ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line_o) ok = 0;
    end
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e, s, a;
    bit ok;
    logic [21:0] v, x;
    repeat (3) @(negedge clk);
    chk(line_o == 1'b0, "R1 line in reset", line_o, 0);
    rst_n = 1;
    quiet(200, ok);
    chk(ok, "R1 idle after reset", ok, 1);

    send_edge(e);
    quiet(256, ok);
    chk(ok, "R2 send without arm", ok, 1);

    send_i = 1; @(negedge clk);
    pulse_arm;
    quiet(256, ok);
    chk(ok, "R2 level without edge", ok, 1);
    send_i = 0;
    quiet(600, ok);

    for (int n = 0; n < 5; n++) begin
      id_i = VEC[n][23:16]; stat_i = VEC[n][15:8];
      pulse_arm;
      go_phase(int'(VEC[n][7:0]));
      send_edge(e);
      wait_start(s);
      chk(s == e + delay_of(int'(VEC[n][7:0])) + 1, "R4 start delay", s - e, delay_of(int'(VEC[n][7:0])) + 1);
      if (s >= 0) begin
        recv(s, v);
        x = frame_exp(VEC[n][23:16], VEC[n][15:8]);
        chk(v == x, "R5 R6 frame", v, x);
      end
      quiet(200, ok);
    end

    go_phase(0); a = cyc;
    pulse_arm;
    wait_cyc(a + DIV * WIN);
    send_edge(e);
    quiet(256, ok);
    chk(ok, "R3 edge after window", ok, 1);

    go_phase(0); a = cyc;
    pulse_arm;
    wait_cyc(a + DIV * WIN - 1);
    id_i = 8'h6B; stat_i = 8'hD2;
    send_edge(e);
    wait_start(s);
    chk(s == e + DIV + 1, "R3 edge on closing boundary", s - e, DIV + 1);
    if (s >= 0) begin
      recv(s, v);
      x = frame_exp(8'h6B, 8'hD2);
      chk(v == x, "R3 frame", v, x);
    end
    quiet(200, ok);

    id_i = 8'h11; stat_i = 8'h22;
    pulse_arm;
    go_phase(10);
    send_edge(e);
    fork
      begin
        wait_start(s);
        if (s >= 0) recv(s, v);
      end
      begin
        wait_cyc(e + delay_of(10));
        id_i = 8'hC3; @(negedge clk); id_i = 8'h3C;
        wait_cyc(e + delay_of(10) + 12 * DIV);
        stat_i = 8'h96; @(negedge clk); stat_i = 8'h69;
      end
    join
    x = frame_exp(8'hC3, 8'h96);
    chk(v[10:0] == x[10:0], "R7 id capture instant", v[10:0], x[10:0]);
    chk(v[21:11] == x[21:11], "R8 status capture instant", v[21:11], x[21:11]);
    quiet(200, ok);

    id_i = 8'hE7; stat_i = 8'h18;
    pulse_arm;
    send_edge(e);
    wait_start(s);
    fork
      recv(s, v);
      begin
        wait_cyc(s + 200);
        pulse_arm;
        send_edge(a);
      end
    join
    x = frame_exp(8'hE7, 8'h18);
    chk(v == x, "R9 frame undisturbed", v, x);
    quiet(300, ok);
    chk(ok, "R9 edge during reply ignored", ok, 1);

    pulse_arm;
    send_edge(e);
    wait_start(s);
    if (s >= 0) recv(s, v);
    quiet(200, ok);
    send_edge(e);
    quiet(256, ok);
    chk(ok, "R9 flag spent after accept", ok, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule